// File: doc/BRIEF.md
# Complement-Checked Serial Number Scanner

The scanner looks through the maker's reserved region of a fuse array for a usable device serial number. Each candidate takes two adjacent words: the serial value, then its bitwise inverse. The scanner starts with the highest pair and works downward. It takes the first pair whose words are exact complements, so the slot written most recently wins.

The array is reached through a word-read port with a request/acknowledge handshake. One read is outstanding at a time. A pulse on `start_i` begins a scan. When the scan ends, `done_o` pulses for one cycle. At that point `serial_o`, `found_o` and `err_o` are valid and they hold until the next scan starts.

If no pair matches, the scanner reports the value word of the last pair it read, the pair at index 2, with `found_o` low. An error response from the port ends the scan at once.

Top module: `serial_scan`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `found_o`, `err_o` and `rd_req_o` are 0 and `serial_o` is 0.
- R2: The first read of a scan goes to word address 0xFE and the second goes to 0xFF.
- R3: Pairs are examined at indices 0xFE, 0xFC, 0xFA and so on, falling by 2 each time. For each pair, the value word at the even address is read before the complement word at the next odd address.
- R4: A pair is valid when its value word equals the bitwise NOT of its complement word. The scan stops at the first valid pair, with `serial_o` set to that pair's value word and `found_o` set to 1.
- R5: Addresses 0 and 1 are never read, even when they hold a valid pair. The last pair examined is at index 2.
- R6: If no pair is valid, the scan stops after pair 2 with `found_o` at 0 and `serial_o` equal to the value word read at address 2.
- R7: While `rd_req_o` is high and `rd_ack_i` is low, the next cycle keeps `rd_req_o` high and `rd_addr_o` unchanged.
- R8: A response with `rd_err_i` set ends the scan with `err_o` at 1, `found_o` at 0 and `serial_o` at 0. No further reads are issued.
- R9: `done_o` is high for exactly one cycle per scan. `busy_o` is high from the cycle after an accepted start until `done_o` rises, and it is low while `done_o` is high.
- R10: A `start_i` pulse during a scan is ignored. The scan continues with no restart and gives the same result.
- R11: `rd_addr_o` never exceeds 0xFF while `rd_req_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a scan when idle |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| found_o | output | 1 | A valid pair was matched |
| err_o | output | 1 | Scan was aborted by a read error |
| serial_o | output | DATA_W | Reported serial value |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Word address of the read |
| rd_ack_i | input | 1 | Read response valid |
| rd_err_i | input | 1 | Response carries an error (valid with ack) |
| rd_data_i | input | DATA_W | Read data (valid with ack) |

## Verification
The complement response for pair 2 can carry three verdicts in the same cycle: a match, the end of the region, and a read error. Several table entries are built to hit these collisions:
- a valid pair placed at index 2, which must give `found_o` and not the fallback;
- an error injected on address 3 while pair 2 is valid, where the error must win and clear `found_o`;
- a valid pair planted at index 0, which must stay unread.

Each case is judged against a model in the bench that walks the same descending order over the bench's own copy of the array. The model predicts the flags, the serial and the exact sequence of acknowledged addresses.

// File: rtl/serial_scan.sv
module serial_scan #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12,
  parameter int FIRST_PAIR = 254,
  parameter int LAST_PAIR  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              found_o,
  output logic              err_o,
  output logic [DATA_W-1:0] serial_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic              rd_err_i,
  input  logic [DATA_W-1:0] rd_data_i
);

  localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(FIRST_PAIR);
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(LAST_PAIR);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] TOP   = ADDR_W'(FIRST_PAIR + 1);

  typedef enum logic [1:0] {S_IDLE, S_VAL, S_CMP} st_t;

  st_t               st;
  logic [ADDR_W-1:0] idx;
  logic [DATA_W-1:0] val_q;

  assign busy_o    = (st != S_IDLE);
  assign rd_req_o  = busy_o;
  assign rd_addr_o = (st == S_CMP) ? idx + ADDR_W'(1) : idx;

  wire take    = rd_req_o & rd_ack_i;
  wire pair_ok = (val_q == ~rd_data_i);
  wire at_last = (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      val_q    <= '0;
      done_o   <= 1'b0;
      found_o  <= 1'b0;
      err_o    <= 1'b0;
      serial_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        S_IDLE: if (start_i) begin
          idx      <= FIRST;
          found_o  <= 1'b0;
          err_o    <= 1'b0;
          serial_o <= '0;
          st       <= S_VAL;
        end
        S_VAL: if (take) begin
          if (rd_err_i) begin
            err_o  <= 1'b1;
            done_o <= 1'b1;
            st     <= S_IDLE;
          end else begin
            val_q <= rd_data_i;
            st    <= S_CMP;
          end
        end
        S_CMP: if (take) begin
          if (rd_err_i) begin
            err_o  <= 1'b1;
            done_o <= 1'b1;
            st     <= S_IDLE;
          end else if (pair_ok) begin
            serial_o <= val_q;
            found_o  <= 1'b1;
            done_o   <= 1'b1;
            st       <= S_IDLE;
          end else if (at_last) begin
            serial_o <= val_q;
            done_o   <= 1'b1;
            st       <= S_IDLE;
          end else begin
            idx <= idx - STEP;
            st  <= S_VAL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));

  // R11
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> rd_addr_o <= TOP);

  // R5
  low_pair_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> rd_addr_o >= LAST);

  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(err_o && found_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !rd_req_o);

  // R8
  err_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> serial_o == '0);

endmodule

// File: tb/serial_scan_bench.sv
module serial_scan_bench;
  localparam int DW = 32;
  localparam int AW = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic start_i = 0;
  logic busy_o, done_o, found_o, err_o, rd_req_o;
  logic [DW-1:0] serial_o;
  logic [AW-1:0] rd_addr_o;
  logic rd_ack_i = 0, rd_err_i = 0;
  logic [DW-1:0] rd_data_i = '0;

  always #2.5 clk = ~clk;

  serial_scan #(.DATA_W(DW), .ADDR_W(AW)) u_serial_scan (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .found_o(found_o), .err_o(err_o),
    .serial_o(serial_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_ack_i(rd_ack_i), .rd_err_i(rd_err_i), .rd_data_i(rd_data_i));

  // {pair_a[7:0], pair_b[7:0], latency[3:0], err_addr[8:0]}; 0xFF = no pair, 0x1FF = no error
  localparam int NV = 9;
  localparam logic [28:0] VEC [NV] = '{
    {8'hFE, 8'hFF, 4'd0, 9'h1FF},
    {8'h80, 8'h40, 4'd1, 9'h1FF},
    {8'h02, 8'hFF, 4'd2, 9'h1FF},
    {8'hFF, 8'hFF, 4'd0, 9'h1FF},
    {8'h00, 8'hFF, 4'd1, 9'h1FF},
    {8'h40, 8'hFF, 4'd0, 9'h0C1},
    {8'h02, 8'hFF, 4'd0, 9'h003},
    {8'h10, 8'hFF, 4'd3, 9'h010},
    {8'h60, 8'hFF, 4'd0, 9'h020}
  };

  logic [DW-1:0] mem [256];
  int lat = 0;
  int err_addr = 511;
  int wcnt = 0;
  int nlog = 0;
  int log_a [600];
  int n_checks = 0, n_fail = 0;
  int cyc = 0;

  int exp_seq [600];
  int exp_n;
  logic exp_found, exp_err;
  logic [DW-1:0] exp_serial;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish (actual cycle %0d, expected < 150000)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      rd_ack_i = 0; rd_err_i = 0; wcnt = 0;
    end else if (rd_ack_i) begin
      rd_ack_i = 0; rd_err_i = 0; wcnt = 0;
    end else if (rd_req_o) begin
      if (wcnt >= lat) begin
        rd_ack_i = 1;
        rd_data_i = mem[rd_addr_o[7:0]];
        rd_err_i = (int'(rd_addr_o) == err_addr);
        if (nlog < 600) log_a[nlog] = int'(rd_addr_o);
        nlog++;
      end else wcnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic fill(input int seed, input int pa, input int pb);
    for (int i = 0; i < 256; i += 2) begin
      mem[i]   = (i * 32'h9E3779B1) ^ (seed * 32'h01000193) ^ 32'h5A5A0000;
      mem[i+1] = ~mem[i] ^ 32'h1;
    end
    if (pa != 255) mem[pa+1] = ~mem[pa];
    if (pb != 255) mem[pb+1] = ~mem[pb];
  endtask

  task automatic model();
    exp_n = 0; exp_found = 0; exp_err = 0; exp_serial = '0;
    for (int p = 254; p >= 2; p -= 2) begin
      exp_seq[exp_n++] = p;
      if (p == err_addr) begin exp_err = 1; return; end
      exp_seq[exp_n++] = p + 1;
      if (p + 1 == err_addr) begin exp_err = 1; return; end
      if (mem[p] == ~mem[p+1]) begin exp_found = 1; exp_serial = mem[p]; return; end
      if (p == 2) begin exp_serial = mem[p]; return; end
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (done_o) begin ok = 1; return; end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  task automatic judge(input string tag);
    bit seq_ok;
    check(found_o == exp_found, "R4/R6", {tag, " found"}, found_o, exp_found);
    check(err_o == exp_err, "R8", {tag, " err"}, err_o, exp_err);
    check(serial_o == exp_serial, "R4/R6/R8", {tag, " serial"}, serial_o, exp_serial);
    seq_ok = (nlog == exp_n);
    for (int k = 0; k < exp_n && k < nlog; k++)
      if (log_a[k] == 0 || log_a[k] == 1 || log_a[k] > 255 || log_a[k] != exp_seq[k]) seq_ok = 0;
    check(seq_ok, "R2/R3/R5/R11", {tag, " read sequence (count)"}, nlog, exp_n);
    check(busy_o == 0, "R9", {tag, " busy low at done"}, busy_o, 0);
    @(negedge clk);
    check(done_o == 0, "R9", {tag, " done one cycle"}, done_o, 0);
    check(nlog == exp_n, "R8", {tag, " no reads after end"}, nlog, exp_n);
  endtask

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy_o == 0 && done_o == 0 && rd_req_o == 0, "R1", "control outputs idle",
          {busy_o, done_o, rd_req_o}, 0);
    check(found_o == 0 && err_o == 0 && serial_o == 0, "R1", "result outputs clear",
          {found_o, err_o}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      fill(v, int'(VEC[v][28:21]), int'(VEC[v][20:13]));
      lat = int'(VEC[v][12:9]);
      err_addr = int'(VEC[v][8:0]);
      nlog = 0;
      model();
      pulse_start();
      check(busy_o == 1, "R9", $sformatf("vec%0d busy after start", v), busy_o, 1);
      wait_done(ok);
      check(ok, "R9", $sformatf("vec%0d done seen", v), ok, 1);
      if (nlog > 0) check(log_a[0] == 254, "R2", $sformatf("vec%0d first addr", v), log_a[0], 254);
      judge($sformatf("vec%0d", v));
    end

    // R10: start pulsed mid-scan is ignored
    fill(77, 255, 255);
    lat = 1; err_addr = 511; nlog = 0;
    model();
    pulse_start();
    repeat (20) @(negedge clk);
    start_i = 1; @(negedge clk); start_i = 0;
    wait_done(ok);
    check(ok, "R10", "done after restart attempt", ok, 1);
    judge("R10 restart-ignored");

    // R7: with long latency, address held while waiting
    fill(5, 255, 255);
    lat = 6; err_addr = 511; nlog = 0;
    model();
    pulse_start();
    repeat (2) @(negedge clk);
    begin
      logic [AW-1:0] a0;
      a0 = rd_addr_o;
      repeat (3) @(negedge clk);
      check(rd_req_o == 1 && rd_addr_o == a0, "R7", "request held stable", rd_addr_o, a0);
    end
    wait_done(ok);
    judge("R7 long latency");

    // R1 reset mid-scan returns outputs to idle
    fill(9, 255, 255); lat = 0; nlog = 0;
    pulse_start();
    repeat (10) @(negedge clk);
    rst_n = 0; @(negedge clk); @(negedge clk);
    check(busy_o == 0 && rd_req_o == 0 && serial_o == 0 && found_o == 0, "R1",
          "reset during scan", {busy_o, rd_req_o}, 0);
    rst_n = 1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule